// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block models a single-port synchronous memory. Every control input is sampled on the rising clock edge, and read data leaves through an output register. The array is split into byte lanes. An access is opened by one of two active-low address strobes. The processor-side strobe always opens a read. The controller-side strobe opens either a read or a one-edge write, depending on the write controls sampled on the same edge. Three chip-enable inputs must all be active for a strobe to open an access. If a strobe arrives while they are not all active, the device is deselected.

Once an access is open, edges with no strobe continue it at the held address:
- If write controls are present, the edge writes the held address.
- If the open access is a read, the edge repeats the read.
- Otherwise the edge does nothing.

The external burst-address sequencer is a separate block that feeds the address. The bidirectional bus is split into `d_i`, `q_o` and a drive-enable `q_oe_o` that a pad wrapper uses. Output enable `oe_n` is asynchronous and gates `q_oe_o` directly. Independent of `oe_n`, the output is forced off after writes and deselects.

Top module: `pipe_burst_sram`

## Requirements
- R1: A strobe opens an access at an edge only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A strobe seen with any of these inactive deselects the device, turns the output off and writes nothing.
- R2: `strobe_p_n` is ignored while `sel1_n`=1. When both strobes are low, only the processor strobe is honoured.
- R3: An access opened by `strobe_p_n` is a read on that edge, whatever the write controls are. A later strobe-less edge carrying write controls writes the held address.
- R4: A controller-strobe edge with write controls active writes the addressed word on that single edge. A read on the next edge returns the new value.
- R5: `gw_n`=0 writes every lane, regardless of `bwe_n` and `bw_n`.
- R6: With `gw_n`=1, lane l (bits [l*LANE_W +: LANE_W]) is written only when `bwe_n`=0 and `bw_n[l]`=0. Other lanes keep their contents, and `bwe_n`=1 writes nothing.
- R7: A read whose address is sampled at edge k drives `q_o` after edge k+1. The output is off between edges k and k+1 when the read follows a write or a deselect.
- R8: A deselect at an edge turns the output off right after that edge, discarding a read result still in flight.
- R9: An edge that writes turns the output off right after it, including the result of a read on the previous edge. The output stays off on strobe-less edges until a strobe opens a read.
- R10: After a read, each strobe-less edge without write controls re-reads the held address. `q_o` keeps showing that word.
- R11: `q_oe_o` follows `oe_n` without waiting for a clock edge: it is low whenever `oe_n`=1.
- R12: After reset the output is off and the device is deselected.
- R13: While deselected, edges without a strobe change nothing, even with write controls active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| sel1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip enable, active high |
| sel3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane byte select, active low |
| d_i | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| q_o | output | LANES*LANE_W | Registered read data |
| q_oe_o | output | 1 | Data bus drive enable |

## Verification
The hardest situation to reach from the ports is a processor-strobe access that carries write controls on its opening edge and is then continued into a real write. The bench shows the opening edge was a read: it holds the strobes off for one edge with no write controls and observes the old word on `q_o`. Only then does it apply a strobe-less write edge and confirm the forced tri-state. Kill cases need a read still in flight when a deselect or write edge arrives, so they are produced back to back. Reference contents come from a behavioural memory that applies byte masks arithmetically across full-array and per-lane sweeps.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } op_e;
endpackage

// File: rtl/psram_cmd_decode.sv
// Per-edge operation decode plus the small state that lets strobe-less
// edges continue an open access at the held address.
module psram_cmd_decode
  import psram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_p_n,
  input  logic              strobe_c_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  lane_we_o
);
  logic              chip_on;
  logic              p_ok;
  logic              seen;
  logic [LANES-1:0]  wr_mask;
  logic              sel_q;
  logic              rd_mode_q;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    chip_on = ~sel1_n & sel2 & ~sel3_n;
    p_ok    = ~strobe_p_n & ~sel1_n;
    seen    = p_ok | ~strobe_c_n;
    if (!gw_n)       wr_mask = '1;
    else if (!bwe_n) wr_mask = ~bw_n;
    else             wr_mask = '0;
  end

  always_comb begin
    op_o   = OP_NONE;
    addr_o = addr_q;
    if (seen) begin
      if (!chip_on) begin
        op_o = OP_DESEL;
      end else begin
        addr_o = addr_i;
        if (p_ok)            op_o = OP_READ;
        else if (|wr_mask)   op_o = OP_WRITE;
        else                 op_o = OP_READ;
      end
    end else if (sel_q) begin
      if (|wr_mask)          op_o = OP_WRITE;
      else if (rd_mode_q)    op_o = OP_READ;
    end
  end

  assign lane_we_o = (op_o == OP_WRITE) ? wr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 1'b0;
      rd_mode_q <= 1'b0;
      addr_q    <= '0;
    end else begin
      case (op_o)
        OP_DESEL: begin
          sel_q     <= 1'b0;
          rd_mode_q <= 1'b0;
        end
        OP_READ: begin
          sel_q     <= 1'b1;
          rd_mode_q <= 1'b1;
          addr_q    <= addr_o;
        end
        OP_WRITE: begin
          sel_q     <= 1'b1;
          rd_mode_q <= 1'b0;
          addr_q    <= addr_o;
        end
        default: ;
      endcase
    end
  end

  AST_PSTROBE_IS_READ: assert property (@(posedge clk) disable iff (rst)
    (!strobe_p_n && !sel1_n && sel2 && !sel3_n) |-> (op_o == OP_READ && lane_we_o == '0)); // R3
  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (op_o == OP_WRITE && !gw_n) |-> (&lane_we_o)); // R5
  AST_CHIP_OFF_DESEL: assert property (@(posedge clk) disable iff (rst)
    ((!strobe_c_n || (!strobe_p_n && !sel1_n)) && (sel1_n || !sel2 || sel3_n)) |-> (op_o == OP_DESEL)); // R1
  AST_IDLE_WHEN_DESEL: assert property (@(posedge clk) disable iff (rst)
    (!sel_q && strobe_c_n && (strobe_p_n || sel1_n)) |-> (op_o == OP_NONE && lane_we_o == '0)); // R13
endmodule

// File: rtl/psram_lane_array.sv
// One inferable RAM per byte lane, single address, registered read.
module psram_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we_i[l]) bank[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      rd_q <= bank[addr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/psram_out_stage.sv
// Output register, valid pipeline and drive-enable masking.
module psram_out_stage #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fire_i,
  input  logic              kill_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              oe_n,
  output logic [DATA_W-1:0] q_o,
  output logic              q_oe_o
);
  logic s1_vld;
  logic q_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      q_vld  <= 1'b0;
    end else begin
      s1_vld <= rd_fire_i;
      q_vld  <= s1_vld & ~kill_i;
    end
  end

  always_ff @(posedge clk) begin
    q_o <= rdata_i;
  end

  assign q_oe_o = q_vld & ~oe_n;
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import psram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    strobe_p_n,
  input  logic                    strobe_c_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*LANE_W-1:0] d_i,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] q_o,
  output logic                    q_oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               op;
  logic [ADDR_W-1:0] op_addr;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rdata;

  psram_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .op_o(op), .addr_o(op_addr), .lane_we_o(lane_we)
  );

  psram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk(clk), .addr_i(op_addr), .lane_we_i(lane_we),
    .wdata_i(d_i), .rdata_o(rdata)
  );

  psram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst),
    .rd_fire_i(op == OP_READ),
    .kill_i(op == OP_WRITE || op == OP_DESEL),
    .rdata_i(rdata), .oe_n(oe_n),
    .q_o(q_o), .q_oe_o(q_oe_o)
  );

  AST_WRITE_BLANKS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WRITE) |=> !q_oe_o); // R9
  AST_DESEL_BLANKS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DESEL) |=> !q_oe_o); // R8
endmodule

// File: tb/pipe_burst_sram_tb_top.sv
`timescale 1ns/1ps
module pipe_burst_sram_tb_top;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = LW * NL;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          pn, cn, s1n, s2, s3n, gwn, bwen, oen;
  logic [NL-1:0] bwn;
  logic [DW-1:0] din;
  logic [DW-1:0] q_o;
  logic          q_oe_o;

  logic [DW-1:0] ref_mem [NW];
  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pipe_burst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .strobe_p_n(pn), .strobe_c_n(cn),
    .sel1_n(s1n), .sel2(s2), .sel3_n(s3n), .gw_n(gwn), .bwe_n(bwen),
    .bw_n(bwn), .d_i(din), .oe_n(oen), .q_o(q_o), .q_oe_o(q_oe_o)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    pn = 1'b1; cn = 1'b1; s1n = 1'b0; s2 = 1'b1; s3n = 1'b0;
    gwn = 1'b1; bwen = 1'b1; bwn = '1; oen = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(int a, int s);
    return DW'((a * 1237) ^ (s * 40503) ^ (a << 9));
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d,
                                         logic g, logic be, logic [NL-1:0] b);
    logic [DW-1:0] r = old;
    for (int l = 0; l < NL; l++)
      if (!g || (!be && !b[l])) r[l*LW +: LW] = d[l*LW +: LW];
    return r;
  endfunction

  task automatic cwrite(input int a, input logic [DW-1:0] d, input logic g,
                        input logic be, input logic [NL-1:0] b);
    quiet();
    cn = 1'b0; addr = AW'(a); din = d; gwn = g; bwen = be; bwn = b;
    tick();
    ref_mem[a] = merge(ref_mem[a], d, g, be, b);
    quiet();
  endtask

  task automatic cread_issue(input int a);
    quiet();
    cn = 1'b0; addr = AW'(a);
  endtask

  task automatic read_check(input int a, input string req);
    cread_issue(a);
    tick();
    quiet();
    tick();
    chk(q_oe_o === 1'b1 && q_o === ref_mem[a], req, q_o, ref_mem[a]);
  endtask

  task automatic sweep(input int lo, input int hi, input string req);
    for (int a = lo; a <= hi; a++) begin
      cread_issue(a);
      tick();
      if (a > lo)
        chk(q_oe_o === 1'b1 && q_o === ref_mem[a-1], req, q_o, ref_mem[a-1]);
    end
    quiet();
    tick();
    chk(q_oe_o === 1'b1 && q_o === ref_mem[hi], req, q_o, ref_mem[hi]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] old;
    quiet();
    addr = '0; din = '0; rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(q_oe_o === 1'b0, "R12 reset output off", DW'(q_oe_o), 0);

    // R5 / R4: fill every word with a global write, then read the whole array
    for (int a = 0; a < NW; a++) cwrite(a, pat(a, 1), 1'b0, 1'b1, '1);
    cread_issue(0);
    tick();
    chk(q_oe_o === 1'b0, "R7 off in first cycle after write", DW'(q_oe_o), 0);
    quiet();
    tick();
    chk(q_oe_o === 1'b1 && q_o === ref_mem[0], "R7 latency", q_o, ref_mem[0]);
    sweep(0, NW - 1, "R5 full-array sweep");

    // R6: every lane-select pattern; R5: global write overrides byte controls
    for (int a = 0; a < 32; a++)
      for (int m = 0; m < 4; m++) cwrite(a, pat(a, m + 7), 1'b1, 1'b0, ~NL'(m));
    for (int a = 32; a < 40; a++) cwrite(a, pat(a, 21), 1'b0, 1'b1, '1);
    for (int a = 40; a < 48; a++) cwrite(a, pat(a, 33), 1'b1, 1'b1, '0);
    sweep(0, 31, "R6 byte lanes");
    sweep(32, 39, "R5 global override");
    sweep(40, 47, "R6 bwe_n high writes nothing");

    // R4: one-edge write followed immediately by a read
    cwrite(200, pat(200, 55), 1'b1, 1'b0, 2'b10);
    read_check(200, "R4 write then read");

    // R2 + R3: both strobes low with write controls -> a read; then a strobe-less write
    old = ref_mem[100];
    quiet();
    pn = 1'b0; cn = 1'b0; addr = 8'd100; gwn = 1'b0; din = pat(100, 77);
    tick();
    quiet();
    tick();
    chk(q_oe_o === 1'b1 && q_o === old, "R2 processor strobe wins, reads", q_o, old);
    gwn = 1'b0; din = pat(100, 77); addr = 8'd3;
    tick();
    ref_mem[100] = pat(100, 77);
    chk(q_oe_o === 1'b0, "R9 write edge blanks output", DW'(q_oe_o), 0);
    quiet();
    tick();
    chk(q_oe_o === 1'b0, "R9 stays off without strobe", DW'(q_oe_o), 0);
    read_check(100, "R3 continuation write at held address");

    // R9: write on the edge right after a read kills the read
    cread_issue(60);
    tick();
    cwrite(61, pat(61, 90), 1'b0, 1'b1, '1);
    chk(q_oe_o === 1'b0, "R9 in-flight read killed by write", DW'(q_oe_o), 0);

    // R8: deselect right after a read
    cread_issue(5);
    tick();
    quiet();
    cn = 1'b0; s2 = 1'b0;
    tick();
    chk(q_oe_o === 1'b0, "R8 deselect kills read", DW'(q_oe_o), 0);
    quiet();
    tick();
    chk(q_oe_o === 1'b0, "R8 stays off", DW'(q_oe_o), 0);
    // R13: deselected, no strobe, write controls active
    gwn = 1'b0; addr = 8'd5; din = ~ref_mem[5];
    tick();
    chk(q_oe_o === 1'b0, "R13 output off", DW'(q_oe_o), 0);
    cread_issue(5);
    tick();
    chk(q_oe_o === 1'b0, "R7 off in first cycle after deselect", DW'(q_oe_o), 0);
    quiet();
    tick();
    chk(q_oe_o === 1'b1 && q_o === ref_mem[5], "R13 word unchanged", q_o, ref_mem[5]);

    // R1: strobes with an inactive chip enable write nothing
    quiet();
    cn = 1'b0; s3n = 1'b1; gwn = 1'b0; addr = 8'd6; din = ~ref_mem[6];
    tick();
    chk(q_oe_o === 1'b0, "R1 chip off deselects", DW'(q_oe_o), 0);
    quiet();
    pn = 1'b0; s2 = 1'b0; gwn = 1'b0; addr = 8'd6; din = ~ref_mem[6];
    tick();
    quiet();
    read_check(6, "R1 no write with chip off");

    // R2: processor strobe ignored while sel1_n is high (read continues)
    quiet();
    pn = 1'b0; s1n = 1'b1;
    tick();
    chk(q_oe_o === 1'b1 && q_o === ref_mem[6], "R2 ignored with sel1_n high", q_o, ref_mem[6]);

    // R10: continuation reads
    read_check(10, "R10 start");
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(q_oe_o === 1'b1 && q_o === ref_mem[10], "R10 repeat read", q_o, ref_mem[10]);
    end

    // R11: asynchronous output enable
    oen = 1'b1;
    #0.5;
    chk(q_oe_o === 1'b0, "R11 oe_n high", DW'(q_oe_o), 0);
    oen = 1'b0;
    #0.5;
    chk(q_oe_o === 1'b1, "R11 oe_n low", DW'(q_oe_o), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule